// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This unit controls the bypass paths of a five-stage load/store integer pipeline. Each cycle it looks at the instruction word in the decode slot. It compares that word's source register fields with the destinations of the two older instructions still in flight. From that it chooses where each operand of the execute stage comes from: the register file, the result waiting at the end of execute, or the result waiting at the end of memory. It makes the same choice for the input of the branch zero test. A separate select, registered one stage later, steers loaded data straight onto the data-memory write input of a store that comes right after the load.

The unit keeps its own shadow copy of the decode/execute and execute/memory control fields. It fills this copy from the decode stream, so the pipeline only has to present the decode word and a valid flag. Forwarding selects are worked out during decode and registered into the execute stage, which keeps the comparator tree out of the execute-stage timing path. When a load is followed directly by an instruction that needs the loaded value in execute, `stall` rises in the same cycle. The pipeline then holds its PC and decode register, and the unit itself places a no-op bubble into its execute slot. Any slot the fetch side cancels is presented with the valid flag low and behaves as a bubble.

Top module: `hz_fwd_unit`

## Requirements
- R1: Field decode: opcode is bits [31:26], first source [25:21], second source [20:16]. Opcode 6'h00 is register-register: it reads both sources and writes [15:11]. Opcode 6'h23 is a load: it reads the first source and writes [20:16]. Opcode 6'h2B is a store: it reads the first source as base and [20:16] as store data, and writes nothing. Opcodes 6'h04 and 6'h05 are branches: they read the first source and write nothing. Opcode 6'h02 is a jump: it reads and writes nothing. Every other opcode is register-immediate: it reads the first source and writes [20:16].
- R2: Select codes are 0 for the register file, 1 for the execute/memory ALU result and 2 for the memory/writeback result. When a non-load instruction one ahead writes a register that the decode instruction reads, the matching ALU operand select (ex_sel_a for the first source, ex_sel_b for the second) is 1. It appears in the cycle after the decode instruction is accepted.
- R3: When only the instruction two ahead writes a register that the decode instruction reads, the matching select is 2. This holds whether that instruction is an ALU operation or a load.
- R4: When the instructions one and two ahead both write the same source register, the younger one wins and the select is 1.
- R5: Register 0 is never a forwarding source and never causes a stall. A source of 0 always yields select 0.
- R6: When the decode instruction is valid and reads the destination of a load one ahead, `stall` is 1 in that same cycle. For a store, this applies only to its base register. During a stall the execute stage receives a bubble, so all three execute selects are 0 in the next cycle. When the held instruction is presented again, it then uses select 2.
- R7: A store whose data register equals the destination of the load directly ahead of it does not stall. Its ex_sel_b is 0, and mem_sel_store is 1 two cycles after the store is accepted, while the store is in the memory stage. mem_sel_store is 0 when the producer one ahead is not a load.
- R8: ex_sel_zero follows the first-source forwarding rule for branch opcodes, and is 0 for every other instruction.
- R9: A decode slot with dec_valid low never stalls and travels down the pipeline as a bubble that forwards nothing.
- R10: While rst is high, and in the first cycle after it, stall and all select outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_instr | input | 32 | Instruction word in the decode slot |
| dec_valid | input | 1 | Decode slot holds a live instruction |
| stall | output | 1 | Hold PC and decode register; a bubble enters execute |
| ex_sel_a | output | 2 | Source select for the first ALU operand in execute |
| ex_sel_b | output | 2 | Source select for the second ALU operand / store data in execute |
| ex_sel_zero | output | 2 | Source select for the branch zero-test input in execute |
| mem_sel_store | output | 1 | Route memory/writeback load data to the data-memory write input |

## Verification
The bench goes after the cases where a careless unit picks the older value or stalls at the wrong time:
- Both older stages write the same register. A unit with the priority reversed would feed the stale result from two ahead.
- A load is followed directly by a store of the loaded register. A unit that treated store data like any other operand would insert a needless bubble, or would bypass the wrong value through the execute-stage select.
- A load is followed by a consumer, a branch or a store base. Here a missing stall would let the dependent instruction run one cycle too early, and a missing bubble would leave stale selects in execute.
- A consumer reads register 0, reads a field that is only a destination in another format, or sits behind a decode slot with dec_valid low. Each of these catches a unit that matches on the wrong field or forwards from a cancelled slot.

// File: rtl/hz_pkg.sv
package hz_pkg;

  parameter int unsigned HZ_IW   = 32;
  parameter int unsigned HZ_RAW  = 5;
  parameter int unsigned HZ_OPW  = 6;
  parameter int unsigned HZ_SELW = 2;
  parameter int unsigned HZ_NOPS = 2;

  localparam int unsigned OP_LSB  = HZ_IW - HZ_OPW;
  localparam int unsigned SRC1_LSB = OP_LSB - HZ_RAW;
  localparam int unsigned SRC2_LSB = SRC1_LSB - HZ_RAW;
  localparam int unsigned DST_LSB  = SRC2_LSB - HZ_RAW;

  localparam logic [HZ_OPW-1:0] OPC_REGREG = 6'h00;
  localparam logic [HZ_OPW-1:0] OPC_JUMP   = 6'h02;
  localparam logic [HZ_OPW-1:0] OPC_BREQZ  = 6'h04;
  localparam logic [HZ_OPW-1:0] OPC_BRNEZ  = 6'h05;
  localparam logic [HZ_OPW-1:0] OPC_LOAD   = 6'h23;
  localparam logic [HZ_OPW-1:0] OPC_STORE  = 6'h2B;

  typedef enum logic [HZ_SELW-1:0] {
    SRC_REGFILE = 2'd0,
    SRC_EXMEM   = 2'd1,
    SRC_MEMWB   = 2'd2
  } fwd_src_e;

  typedef struct packed {
    logic [HZ_RAW-1:0] src1;
    logic [HZ_RAW-1:0] src2;
    logic [HZ_RAW-1:0] dst;
    logic              rd1;
    logic              rd2;
    logic              wr;
    logic              ld;
    logic              st;
    logic              br;
  } hz_ctl_t;

endpackage

// File: rtl/hz_decode.sv
module hz_decode
  import hz_pkg::*;
(
  input  logic [HZ_IW-1:0] instr,
  input  logic             valid,
  output hz_ctl_t          ctl
);

  logic [HZ_OPW-1:0] opc;
  assign opc = instr[HZ_IW-1 -: HZ_OPW];

  always_comb begin
    ctl      = '0;
    ctl.src1 = instr[SRC1_LSB +: HZ_RAW];
    ctl.src2 = instr[SRC2_LSB +: HZ_RAW];
    unique case (opc)
      OPC_REGREG: begin
        ctl.rd1 = 1'b1;
        ctl.rd2 = 1'b1;
        ctl.wr  = 1'b1;
        ctl.dst = instr[DST_LSB +: HZ_RAW];
      end
      OPC_LOAD: begin
        ctl.rd1 = 1'b1;
        ctl.wr  = 1'b1;
        ctl.ld  = 1'b1;
        ctl.dst = instr[SRC2_LSB +: HZ_RAW];
      end
      OPC_STORE: begin
        ctl.rd1 = 1'b1;
        ctl.rd2 = 1'b1;
        ctl.st  = 1'b1;
      end
      OPC_BREQZ, OPC_BRNEZ: begin
        ctl.rd1 = 1'b1;
        ctl.br  = 1'b1;
      end
      OPC_JUMP: begin
        ctl.src1 = '0;
        ctl.src2 = '0;
      end
      default: begin
        ctl.rd1 = 1'b1;
        ctl.wr  = 1'b1;
        ctl.dst = instr[SRC2_LSB +: HZ_RAW];
      end
    endcase
    if (!valid) ctl = '0;
  end

endmodule

// File: rtl/hz_match.sv
module hz_match
  import hz_pkg::*;
(
  input  logic [HZ_RAW-1:0] src,
  input  logic              src_used,
  input  logic [HZ_RAW-1:0] dst,
  input  logic              dst_wr,
  output logic              hit
);

  // register 0 is hard-wired zero and never a bypass source
  assign hit = src_used && dst_wr && (dst != '0) && (src == dst);

endmodule

// File: rtl/hz_opsel.sv
module hz_opsel
  import hz_pkg::*;
(
  input  logic [HZ_RAW-1:0] src,
  input  logic              src_used,
  input  logic [HZ_RAW-1:0] near_dst,
  input  logic              near_wr,
  input  logic              near_ld,
  input  logic [HZ_RAW-1:0] far_dst,
  input  logic              far_wr,
  output fwd_src_e          sel,
  output logic              ld_block
);

  logic near_hit;
  logic far_hit;

  hz_match u_near (
    .src(src), .src_used(src_used), .dst(near_dst), .dst_wr(near_wr), .hit(near_hit)
  );

  hz_match u_far (
    .src(src), .src_used(src_used), .dst(far_dst), .dst_wr(far_wr), .hit(far_hit)
  );

  // younger producer shadows the older one, even when it is a load
  always_comb begin
    if (near_hit)     sel = near_ld ? SRC_REGFILE : SRC_EXMEM;
    else if (far_hit) sel = SRC_MEMWB;
    else              sel = SRC_REGFILE;
  end

  assign ld_block = near_hit && near_ld;

endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [HZ_IW-1:0]     dec_instr,
  input  logic                 dec_valid,
  output logic                 stall,
  output logic [HZ_SELW-1:0]   ex_sel_a,
  output logic [HZ_SELW-1:0]   ex_sel_b,
  output logic [HZ_SELW-1:0]   ex_sel_zero,
  output logic                 mem_sel_store
);

  hz_ctl_t dec_c;
  hz_ctl_t idex_c;
  hz_ctl_t exmem_c;

  logic [HZ_RAW-1:0] op_src  [HZ_NOPS];
  logic              op_used [HZ_NOPS];
  fwd_src_e          op_sel  [HZ_NOPS];
  logic              op_blk  [HZ_NOPS];

  fwd_src_e nxt_zero;
  logic     st_hit;

  fwd_src_e sel_a_q, sel_b_q, sel_zero_q;
  logic     st_q;

  hz_decode u_decode (
    .instr(dec_instr), .valid(dec_valid), .ctl(dec_c)
  );

  assign op_src[0]  = dec_c.src1;
  assign op_used[0] = dec_c.rd1;
  assign op_src[1]  = dec_c.src2;
  assign op_used[1] = dec_c.rd2;

  for (genvar g = 0; g < HZ_NOPS; g++) begin : g_opsel
    hz_opsel u_opsel (
      .src(op_src[g]), .src_used(op_used[g]),
      .near_dst(idex_c.dst), .near_wr(idex_c.wr), .near_ld(idex_c.ld),
      .far_dst(exmem_c.dst), .far_wr(exmem_c.wr),
      .sel(op_sel[g]), .ld_block(op_blk[g])
    );
  end

  // store data from a load just ahead is bypassed later, at the memory stage
  assign stall    = op_blk[0] || (op_blk[1] && !dec_c.st);
  assign nxt_zero = dec_c.br ? op_sel[0] : SRC_REGFILE;

  hz_match u_st_match (
    .src(idex_c.src2), .src_used(idex_c.st),
    .dst(exmem_c.dst), .dst_wr(exmem_c.wr && exmem_c.ld),
    .hit(st_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idex_c     <= '0;
      exmem_c    <= '0;
      sel_a_q    <= SRC_REGFILE;
      sel_b_q    <= SRC_REGFILE;
      sel_zero_q <= SRC_REGFILE;
      st_q       <= 1'b0;
    end else begin
      exmem_c <= idex_c;
      st_q    <= st_hit;
      if (stall) begin
        idex_c     <= '0;
        sel_a_q    <= SRC_REGFILE;
        sel_b_q    <= SRC_REGFILE;
        sel_zero_q <= SRC_REGFILE;
      end else begin
        idex_c     <= dec_c;
        sel_a_q    <= op_sel[0];
        sel_b_q    <= op_sel[1];
        sel_zero_q <= nxt_zero;
      end
    end
  end

  assign ex_sel_a      = sel_a_q;
  assign ex_sel_b      = sel_b_q;
  assign ex_sel_zero   = sel_zero_q;
  assign mem_sel_store = st_q;

endmodule

// File: rtl/hz_fwd_unit_chk.sv
module hz_fwd_unit_chk
  import hz_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [HZ_IW-1:0]   dec_instr,
  input logic               dec_valid,
  input logic               stall,
  input logic [HZ_SELW-1:0] ex_sel_a,
  input logic [HZ_SELW-1:0] ex_sel_b,
  input logic [HZ_SELW-1:0] ex_sel_zero,
  input logic               mem_sel_store
);

  AST_STALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    stall |-> dec_valid); // R9

  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall); // R6

  AST_BUBBLE_SELS: assert property (@(posedge clk) disable iff (rst)
    stall |=> (ex_sel_a == '0 && ex_sel_b == '0 && ex_sel_zero == '0)); // R6

  AST_R0_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (dec_instr[SRC1_LSB +: HZ_RAW] == '0 && dec_instr[SRC2_LSB +: HZ_RAW] == '0) |-> !stall); // R5

  AST_R0_NO_FWD: assert property (@(posedge clk) disable iff (rst)
    (dec_instr[SRC1_LSB +: HZ_RAW] == '0 && dec_instr[SRC2_LSB +: HZ_RAW] == '0)
      |=> (ex_sel_a == '0 && ex_sel_b == '0)); // R5

  AST_ZERO_TRACKS_A: assert property (@(posedge clk) disable iff (rst)
    (ex_sel_zero != '0) |-> (ex_sel_zero == ex_sel_a)); // R8

  AST_STORE_BYPASS_LATE: assert property (@(posedge clk) disable iff (rst)
    mem_sel_store |-> ($past(ex_sel_b) == '0)); // R7

endmodule

bind hz_fwd_unit hz_fwd_unit_chk u_chk (
  .clk(clk), .rst(rst), .dec_instr(dec_instr), .dec_valid(dec_valid),
  .stall(stall), .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
  .ex_sel_zero(ex_sel_zero), .mem_sel_store(mem_sel_store)
);

// File: tb/hz_fwd_unit_bench.sv
module hz_fwd_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dec_instr = '0;
  logic        dec_valid = 1'b0;
  logic        stall;
  logic [1:0]  ex_sel_a, ex_sel_b, ex_sel_zero;
  logic        mem_sel_store;

  hz_fwd_unit u_hz_fwd_unit (
    .clk(clk), .rst(rst), .dec_instr(dec_instr), .dec_valid(dec_valid),
    .stall(stall), .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
    .ex_sel_zero(ex_sel_zero), .mem_sel_store(mem_sel_store)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    due;
    int    kind;
    int    expv;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int actual(int kind);
    case (kind)
      0: return int'(stall);
      1: return int'(ex_sel_a);
      2: return int'(ex_sel_b);
      3: return int'(ex_sel_zero);
      default: return int'(mem_sel_store);
    endcase
  endfunction

  function automatic string kname(int kind);
    case (kind)
      0: return "stall";
      1: return "ex_sel_a";
      2: return "ex_sel_b";
      3: return "ex_sel_zero";
      default: return "mem_sel_store";
    endcase
  endfunction

  // monitor: compares every item that falls due in this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        n_cmp++;
        if (actual(q[i].kind) != q[i].expv) begin
          n_bad++;
          $display("FAIL %s %s cyc=%0d actual=%0d expected=%0d",
                   q[i].tag, kname(q[i].kind), cyc, actual(q[i].kind), q[i].expv);
        end
        q.delete(i);
      end
    end
  end

  function automatic void push(int due, int kind, int expv, string tag);
    exp_t e;
    e.due = due; e.kind = kind; e.expv = expv; e.tag = tag;
    q.push_back(e);
  endfunction

  function automatic logic [31:0] rr(logic [4:0] d, logic [4:0] s, logic [4:0] t);
    return {6'h00, s, t, d, 11'h000};
  endfunction
  function automatic logic [31:0] ld(logic [4:0] t, logic [4:0] s);
    return {6'h23, s, t, 16'h0000};
  endfunction
  function automatic logic [31:0] sw(logic [4:0] t, logic [4:0] s);
    return {6'h2B, s, t, 16'h000C};
  endfunction
  function automatic logic [31:0] bz(logic [4:0] s);
    return {6'h04, s, 5'd0, 16'h0010};
  endfunction
  function automatic logic [31:0] bnz(logic [4:0] s);
    return {6'h05, s, 5'd0, 16'h0010};
  endfunction
  function automatic logic [31:0] imm(logic [4:0] t, logic [4:0] s);
    return {6'h08, s, t, 16'h0004};
  endfunction
  function automatic logic [31:0] jmp(logic [4:0] f);
    return {6'h02, f, 21'h0};
  endfunction

  // driver: one decode slot per call, expected results queued for the monitor
  task automatic step(logic [31:0] ins, logic v, int e_st, int e_a, int e_b,
                      int e_z, int e_m, string tag);
    @(posedge clk);
    #1;
    dec_instr = ins;
    dec_valid = v;
    push(cyc,     0, e_st, tag);
    push(cyc + 1, 1, e_a,  tag);
    push(cyc + 1, 2, e_b,  tag);
    push(cyc + 1, 3, e_z,  tag);
    push(cyc + 2, 4, e_m,  tag);
  endtask

  task automatic nop2();
    step(32'h0, 1'b1, 0, 0, 0, 0, 0, "nop");
    step(32'h0, 1'b1, 0, 0, 0, 0, 0, "nop");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R10: outputs quiet during reset
    @(posedge clk);
    #1;
    for (int k = 0; k < 5; k++) push(cyc, k, 0, "R10");
    @(posedge clk);
    @(posedge clk);
    #1;
    rst = 1'b0;
    for (int k = 1; k < 5; k++) push(cyc, k, 0, "R10");

    // R2 / R3 basic distances
    step(rr(5'd1, 5'd2, 5'd3), 1, 0, 0, 0, 0, 0, "R2");
    step(rr(5'd4, 5'd1, 5'd5), 1, 0, 1, 0, 0, 0, "R2");
    step(rr(5'd6, 5'd7, 5'd1), 1, 0, 0, 2, 0, 0, "R3");
    step(rr(5'd8, 5'd4, 5'd4), 1, 0, 2, 2, 0, 0, "R3");
    nop2();

    // R4 priority
    step(rr(5'd10, 5'd2, 5'd3),   1, 0, 0, 0, 0, 0, "R4");
    step(rr(5'd10, 5'd10, 5'd3),  1, 0, 1, 0, 0, 0, "R4");
    step(rr(5'd11, 5'd10, 5'd10), 1, 0, 1, 1, 0, 0, "R4");
    nop2();

    // R5 register zero
    step(rr(5'd0, 5'd2, 5'd3), 1, 0, 0, 0, 0, 0, "R5");
    step(rr(5'd5, 5'd0, 5'd0), 1, 0, 0, 0, 0, 0, "R5");
    step(ld(5'd0, 5'd2),       1, 0, 0, 0, 0, 0, "R5");
    step(rr(5'd1, 5'd0, 5'd0), 1, 0, 0, 0, 0, 0, "R5");
    nop2();

    // R6 load-use stall then retry
    step(ld(5'd12, 5'd2),        1, 0, 0, 0, 0, 0, "R6");
    step(rr(5'd13, 5'd12, 5'd3), 1, 1, 0, 0, 0, 0, "R6");
    step(rr(5'd13, 5'd12, 5'd3), 1, 0, 2, 0, 0, 0, "R6");
    nop2();

    // R3 load two ahead needs no stall
    step(ld(5'd14, 5'd2),        1, 0, 0, 0, 0, 0, "R3");
    step(32'h0,                  1, 0, 0, 0, 0, 0, "R3");
    step(rr(5'd15, 5'd3, 5'd14), 1, 0, 0, 2, 0, 0, "R3");
    nop2();

    // R7 load then store of loaded register
    step(ld(5'd16, 5'd2),  1, 0, 0, 0, 0, 0, "R7");
    step(sw(5'd16, 5'd3),  1, 0, 0, 0, 0, 1, "R7");
    nop2();
    step(rr(5'd21, 5'd2, 5'd3), 1, 0, 0, 0, 0, 0, "R7");
    step(sw(5'd21, 5'd2),       1, 0, 0, 1, 0, 0, "R7");
    nop2();

    // R6 load feeding a store base
    step(ld(5'd17, 5'd2), 1, 0, 0, 0, 0, 0, "R6");
    step(sw(5'd5, 5'd17), 1, 1, 0, 0, 0, 0, "R6");
    step(sw(5'd5, 5'd17), 1, 0, 2, 0, 0, 0, "R6");
    nop2();

    // R8 branch zero test
    step(rr(5'd18, 5'd2, 5'd3), 1, 0, 0, 0, 0, 0, "R8");
    step(bz(5'd18),             1, 0, 1, 0, 1, 0, "R8");
    step(32'h0,                 1, 0, 0, 0, 0, 0, "R8");
    step(rr(5'd19, 5'd2, 5'd3), 1, 0, 0, 0, 0, 0, "R8");
    step(32'h0,                 1, 0, 0, 0, 0, 0, "R8");
    step(bnz(5'd19),            1, 0, 2, 0, 2, 0, "R8");
    step(ld(5'd20, 5'd2),       1, 0, 0, 0, 0, 0, "R8");
    step(bz(5'd20),             1, 1, 0, 0, 0, 0, "R8");
    step(bz(5'd20),             1, 0, 2, 0, 2, 0, "R8");
    nop2();

    // R9 invalid slot
    step(ld(5'd22, 5'd2),         1, 0, 0, 0, 0, 0, "R9");
    step(rr(5'd23, 5'd22, 5'd22), 0, 0, 0, 0, 0, 0, "R9");
    step(rr(5'd24, 5'd22, 5'd0),  1, 0, 2, 0, 0, 0, "R9");
    nop2();

    // R1 field positions per format
    step(imm(5'd25, 5'd2),        1, 0, 0, 0, 0, 0, "R1");
    step(rr(5'd26, 5'd25, 5'd0),  1, 0, 1, 0, 0, 0, "R1");
    step(rr(5'd27, 5'd2, 5'd28),  1, 0, 0, 0, 0, 0, "R1");
    step(rr(5'd29, 5'd28, 5'd0),  1, 0, 0, 0, 0, 0, "R1");
    step(ld(5'd30, 5'd2),         1, 0, 0, 0, 0, 0, "R1");
    step(jmp(5'd30),              1, 0, 0, 0, 0, 0, "R1");
    step(32'h0,                   1, 0, 0, 0, 0, 0, "R1");
    step(sw(5'd9, 5'd2),          1, 0, 0, 0, 0, 0, "R1");
    step(rr(5'd1, 5'd9, 5'd0),    1, 0, 0, 0, 0, 0, "R1");
    nop2();

    repeat (4) @(posedge clk);
    @(negedge clk);
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard pending actual=%0d expected=0", q.size());
    end
    finish_run();
  end

endmodule